// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block is the digital core of a 32-position resistor ladder trimmer. A host steers it with three slow control lines: an active-low select, a step strobe and a direction level. While the block is selected, each high-to-low edge of the strobe moves the wiper one tap up or down. The position saturates at either end instead of wrapping. A one-hot bus of 32 lines drives the transfer gates of the analog ladder, and a binary copy of the position is also provided.

A retained-position register stands in for nonvolatile storage. The host releases select to end a session, and the strobe level at that moment picks the outcome. If the strobe is high, the current position is written into the retained register and a store period of programmable length starts. During that period the block reports busy and ignores all stepping and release activity. If the strobe is low, nothing is written and the wiper keeps its place. The block has two resets. The power-on reset models a blank part and puts both the wiper and the retained register at mid-scale. The warm reset models a power-up recall and reloads the wiper from the retained register.

Every control input passes through a synchronizer before its edges are detected. A change at a pin therefore shows at the outputs a fixed few cycles later.

Top module: `tw_wiper_ctrl`

## Requirements
- R1: Exactly one bit of `tap_sel` is high at all times, and its index equals `wiper_pos`.
- R2: After power-on reset, `wiper_pos` is 16 (mid-scale), `tap_sel` has bit 16 set and `store_busy` is low.
- R3: While `sel_n` is low and no store is running, a falling edge of `step` moves the wiper up one tap when `dir_up` is 1 and down one tap when `dir_up` is 0.
- R4: The position saturates: a step up at 31 leaves it at 31 and a step down at 0 leaves it at 0.
- R5: While `sel_n` is high, edges on `step` do not change the position.
- R6: A rising edge of `sel_n` while `step` is high copies the position into the retained register. `store_busy` then goes high for STORE_CYCLES cycles.
- R7: A rising edge of `sel_n` while `step` is low stores nothing, keeps the position and leaves `store_busy` low.
- R8: A warm reset (`rst_n` low) reloads `wiper_pos` from the retained register, and the retained register keeps its value.
- R9: While `store_busy` is high, strobe edges do not move the wiper and a release of `sel_n` does not start another store.
- R10: A strobe fall that reaches the block in the same cycle as a release of `sel_n` neither moves the wiper nor starts a store.
- R11: `dir_up` may change while `sel_n` stays low. Later steps in the same session follow the new direction.
- R12: A rising edge of `step` never moves the wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; sets retained value and wiper to mid-scale |
| rst_n | input | 1 | Synchronous warm reset, active low; recalls the wiper from the retained value |
| sel_n | input | 1 | Active-low select, asynchronous to `clk` |
| step | input | 1 | Step strobe; falling edge moves the wiper, asynchronous to `clk` |
| dir_up | input | 1 | Direction: 1 up, 0 down, asynchronous to `clk` |
| tap_sel | output | 32 | One-hot tap select for the ladder |
| wiper_pos | output | 5 | Binary wiper position |
| store_busy | output | 1 | High while a store period runs |

## Verification
Two decisions can fall on the same synchronized cycle: stepping the wiper and judging a release. The bench provokes this by dropping `step` and raising `sel_n` on the same clock. The expected result is an unmoved wiper with `store_busy` low. A following warm reset must then bring back the older retained value, not the current position. The store period also overlaps a second session: steps and a strobe-high release during busy must change nothing, and a later recall proves that no second write took place.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic {TW_DOWN = 1'b0, TW_UP = 1'b1} tw_dir_e;

   // idle levels of the synchronized control vector {sel_n, step, dir_up}
   localparam logic [2:0] TW_CTRL_IDLE = 3'b110;
   localparam int TW_CTRL_SEL  = 2;
   localparam int TW_CTRL_STEP = 1;
   localparam int TW_CTRL_DIR  = 0;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE = '0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tw_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               chain[s] <= IDLE;
            end else if (!rst_n) begin
               chain[s] <= IDLE;
            end else begin
               chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_store_seq.sv
module tw_store_seq #(
   parameter int POS_W = 5,
   parameter int STORE_CYCLES = 16,
   parameter logic [POS_W-1:0] BLANK_POS = '0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             s_sel_n,
   input  logic             s_step,
   input  logic [POS_W-1:0] cur_pos,
   output logic             move_en,
   output logic [POS_W-1:0] nv_pos,
   output logic             busy
);
   localparam int CNT_W = (STORE_CYCLES < 2) ? 1 : $clog2(STORE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYCLES);

   generate
      if (STORE_CYCLES < 1) begin : g_bad
         $error("tw_store_seq needs a store period of at least one cycle");
      end
   endgenerate

   logic             prev_sel_n;
   logic             prev_step;
   logic [CNT_W-1:0] busy_cnt;
   logic             step_fall;
   logic             sel_rise;
   logic             commit;

   assign step_fall = prev_step & ~s_step;
   assign sel_rise  = ~prev_sel_n & s_sel_n;
   assign busy      = (busy_cnt != '0);
   assign move_en   = step_fall & ~s_sel_n & ~busy;
   assign commit    = sel_rise & s_step & ~busy;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         prev_sel_n <= 1'b1;
         prev_step  <= 1'b1;
      end else if (!rst_n) begin
         prev_sel_n <= 1'b1;
         prev_step  <= 1'b1;
      end else begin
         prev_sel_n <= s_sel_n;
         prev_step  <= s_step;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_cnt <= '0;
      end else if (!rst_n) begin
         busy_cnt <= '0;
      end else if (commit) begin
         busy_cnt <= CNT_LOAD;
      end else if (busy) begin
         busy_cnt <= busy_cnt - 1'b1;
      end
   end

   // retained value survives the warm reset; only power-on clears it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         nv_pos <= BLANK_POS;
      end else if (rst_n && commit) begin
         nv_pos <= cur_pos;
      end
   end
endmodule

// File: rtl/tw_counter.sv
module tw_counter
   import tw_pkg::*;
#(
   parameter int POS_W = 5,
   parameter logic [POS_W-1:0] BLANK_POS = '0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic [POS_W-1:0] recall_pos,
   input  logic             move_en,
   input  tw_dir_e          dir,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] POS_TOP = '1;
   localparam logic [POS_W-1:0] POS_BOT = '0;

   logic at_top;
   logic at_bot;

   assign at_top = (pos == POS_TOP);
   assign at_bot = (pos == POS_BOT);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pos <= BLANK_POS;
      end else if (!rst_n) begin
         pos <= recall_pos;
      end else if (move_en) begin
         if (dir == TW_UP && !at_top) begin
            pos <= pos + 1'b1;
         end else if (dir == TW_DOWN && !at_bot) begin
            pos <= pos - 1'b1;
         end
      end
   end
endmodule

// File: rtl/tw_decode.sv
module tw_decode #(
   parameter int POS_W = 5,
   localparam int TAPS = 1 << POS_W
) (
   input  logic [POS_W-1:0] pos,
   output logic [TAPS-1:0]  onehot
);
   generate
      for (genvar i = 0; i < TAPS; i++) begin : g_tap
         assign onehot[i] = (pos == POS_W'(i));
      end
   endgenerate
endmodule

// File: rtl/tw_wiper_ctrl.sv
module tw_wiper_ctrl
   import tw_pkg::*;
#(
   parameter int POS_W = 5,
   parameter int SYNC_STAGES = 2,
   parameter int STORE_CYCLES = 1250000,
   localparam int TAPS = 1 << POS_W
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            rst_n,
   input  logic            sel_n,
   input  logic            step,
   input  logic            dir_up,
   output logic [TAPS-1:0] tap_sel,
   output logic [POS_W-1:0] wiper_pos,
   output logic            store_busy
);
   localparam logic [POS_W-1:0] BLANK_POS = POS_W'(TAPS / 2);

   generate
      if (POS_W < 2 || POS_W > 8) begin : g_bad_width
         $error("tw_wiper_ctrl: POS_W out of range");
      end
   endgenerate

   logic [2:0]       ctrl_sync;
   logic             move_en;
   logic [POS_W-1:0] stored_pos;
   tw_dir_e          dir_s;

   tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .IDLE(TW_CTRL_IDLE)) u_sync (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .d({sel_n, step, dir_up}), .q(ctrl_sync)
   );

   assign dir_s = tw_dir_e'(ctrl_sync[TW_CTRL_DIR]);

   tw_store_seq #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES), .BLANK_POS(BLANK_POS)) u_store (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .s_sel_n(ctrl_sync[TW_CTRL_SEL]), .s_step(ctrl_sync[TW_CTRL_STEP]),
      .cur_pos(wiper_pos), .move_en(move_en), .nv_pos(stored_pos), .busy(store_busy)
   );

   tw_counter #(.POS_W(POS_W), .BLANK_POS(BLANK_POS)) u_count (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .recall_pos(stored_pos), .move_en(move_en), .dir(dir_s), .pos(wiper_pos)
   );

   tw_decode #(.POS_W(POS_W)) u_dec (
      .pos(wiper_pos), .onehot(tap_sel)
   );
endmodule

// File: rtl/tw_wiper_ctrl_chk.sv
module tw_wiper_ctrl_chk #(
   parameter int POS_W = 5,
   parameter int SYNC_STAGES = 2,
   localparam int TAPS = 1 << POS_W
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             sel_n,
   input logic [TAPS-1:0]  tap_sel,
   input logic [POS_W-1:0] wiper_pos,
   input logic             store_busy,
   input logic [POS_W-1:0] stored_pos
);
   localparam logic [POS_W-1:0] TOP = '1;
   localparam int RUN_W = $clog2(SYNC_STAGES + 3);

   logic [RUN_W-1:0] desel_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         desel_run <= '0;
      end else if (!sel_n) begin
         desel_run <= '0;
      end else if (desel_run <= RUN_W'(SYNC_STAGES)) begin
         desel_run <= desel_run + 1'b1;
      end
   end

   a_r1_onehot_match: assert property (@(posedge clk) disable iff (!por_n)
      ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

   a_r3_single_step: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n ##1 rst_n) |->
         ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)}) ||
         ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} + 1'b1) ||
         ({1'b0, wiper_pos} + 1'b1 == {1'b0, $past(wiper_pos)}));

   a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n && wiper_pos == TOP ##1 rst_n) |-> (wiper_pos != '0));

   a_r4_no_wrap_bot: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n && wiper_pos == '0 ##1 rst_n) |-> (wiper_pos != TOP));

   a_r5_deselected_still: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n && desel_run > RUN_W'(SYNC_STAGES)) |=> (!rst_n || $stable(wiper_pos)));

   a_r6_store_copies_pos: assert property (@(posedge clk) disable iff (!por_n)
      $rose(store_busy) |-> (stored_pos == $past(wiper_pos)));

   a_r7_write_only_on_store: assert property (@(posedge clk) disable iff (!por_n)
      !$stable(stored_pos) |-> $rose(store_busy));

   a_r9_busy_freezes: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n && store_busy ##1 rst_n) |-> $stable(wiper_pos));
endmodule

bind tw_wiper_ctrl tw_wiper_ctrl_chk #(.POS_W(POS_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_n(sel_n),
   .tap_sel(tap_sel), .wiper_pos(wiper_pos), .store_busy(store_busy),
   .stored_pos(stored_pos)
);

// File: tb/tw_wiper_ctrl_bench.sv
`timescale 1ns/1ps
module tw_wiper_ctrl_bench;
   localparam int POS_W = 5;
   localparam int TAPS = 1 << POS_W;
   localparam int STORE_CYC = 40;
   localparam int SETTLE = 6;

   typedef struct {
      string tag;
      int    pos;
      bit    busy;
   } exp_t;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_n = 1'b1;
   logic sel_n = 1'b1;
   logic step = 1'b1;
   logic dir_up = 1'b0;
   logic [TAPS-1:0]  tap_sel;
   logic [POS_W-1:0] wiper_pos;
   logic             store_busy;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   int   m_pos = 16;
   int   m_nv = 16;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   tw_wiper_ctrl #(.POS_W(POS_W), .SYNC_STAGES(2), .STORE_CYCLES(STORE_CYC)) u_tw_wiper_ctrl (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_n(sel_n), .step(step),
      .dir_up(dir_up), .tap_sel(tap_sel), .wiper_pos(wiper_pos), .store_busy(store_busy)
   );

   // monitor: pops expected items and compares away from the rising edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            exp_t e;
            logic [TAPS-1:0] want_taps;
            e = sb_q.pop_front();
            want_taps = '0;
            want_taps[e.pos] = 1'b1;
            total++;
            if (wiper_pos !== POS_W'(e.pos) || tap_sel !== want_taps || store_busy !== e.busy) begin
               bad++;
               $display("FAIL %s: pos=%0d taps=%h busy=%0b expected pos=%0d taps=%h busy=%0b",
                        e.tag, wiper_pos, tap_sel, store_busy, e.pos, want_taps, e.busy);
            end
         end
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic expect_now(input string tag, input bit busy);
      exp_t e;
      e.tag = tag; e.pos = m_pos; e.busy = busy;
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   function automatic void model_step(input bit up);
      if (up && m_pos < TAPS - 1) m_pos++;
      else if (!up && m_pos > 0) m_pos--;
   endfunction

   // full strobe pulse; live=1 when the fall should act on the wiper
   task automatic pulse(input string tag, input bit live, input bit busy);
      step = 1'b0;
      wait_cyc(SETTLE);
      if (live) model_step(dir_up);
      expect_now({tag, " fall"}, busy);
      step = 1'b1;
      wait_cyc(SETTLE);
      expect_now({tag, " R12 rise"}, busy);
   endtask

   task automatic warm_reset(input string tag);
      rst_n = 1'b0;
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(2);
      m_pos = m_nv;
      expect_now(tag, 1'b0);
   endtask

   initial begin
      wait_cyc(3);
      por_n = 1'b1;
      wait_cyc(2);
      expect_now("R2 power-on mid-scale", 1'b0);

      // R5: strobe while deselected
      dir_up = 1'b1;
      wait_cyc(SETTLE);
      pulse("R5 deselected", 1'b0, 1'b0);

      // R3 up steps in a session
      sel_n = 1'b0;
      wait_cyc(SETTLE);
      for (int i = 0; i < 3; i++) pulse("R3 up", 1'b1, 1'b0);
      // R11 reverse within the same session
      dir_up = 1'b0;
      wait_cyc(SETTLE);
      for (int i = 0; i < 2; i++) pulse("R11 down same session", 1'b1, 1'b0);

      // R6 release with strobe high: store
      sel_n = 1'b1;
      m_nv = m_pos;
      wait_cyc(4);
      expect_now("R6 store busy", 1'b1);
      // R9: activity during busy is ignored
      sel_n = 1'b0;
      dir_up = 1'b1;
      wait_cyc(4);
      pulse("R9 step during busy", 1'b0, 1'b1);
      wait_cyc(STORE_CYC + 10);
      expect_now("R6 busy ends", 1'b0);

      // second store attempt during busy: start a store, then release again while busy
      // (selection still held; move first so a new store would differ)
      for (int i = 0; i < 2; i++) pulse("R3 up again", 1'b1, 1'b0);
      sel_n = 1'b1;
      m_nv = m_pos;
      wait_cyc(4);
      expect_now("R6 second store", 1'b1);
      sel_n = 1'b0;
      wait_cyc(4);
      pulse("R9 fall in busy", 1'b0, 1'b1);
      sel_n = 1'b1;
      wait_cyc(4);
      expect_now("R9 release in busy", 1'b1);
      wait_cyc(STORE_CYC + 10);

      // R4 top saturation
      sel_n = 1'b0;
      dir_up = 1'b1;
      wait_cyc(SETTLE);
      for (int i = 0; i < 16; i++) pulse("R4 climb", 1'b1, 1'b0);
      expect_now("R4 saturate top", 1'b0);

      // R7 release with strobe low: strobe drops first (saturated, no move)
      step = 1'b0;
      wait_cyc(SETTLE);
      sel_n = 1'b1;
      wait_cyc(SETTLE);
      expect_now("R7 no store", 1'b0);
      step = 1'b1;
      wait_cyc(SETTLE);
      expect_now("R5 rise while deselected", 1'b0);

      // R8 recall: retained value predates the R7 and R9 attempts
      warm_reset("R8 recall after R7 R9");

      // R4 bottom saturation and store of zero
      sel_n = 1'b0;
      dir_up = 1'b0;
      wait_cyc(SETTLE);
      for (int i = 0; i < 20; i++) pulse("R4 descend", 1'b1, 1'b0);
      expect_now("R4 saturate bottom", 1'b0);
      sel_n = 1'b1;
      m_nv = m_pos;
      wait_cyc(STORE_CYC + 10);
      warm_reset("R8 recall zero");

      // R10 strobe fall coinciding with release
      sel_n = 1'b0;
      dir_up = 1'b1;
      wait_cyc(SETTLE);
      for (int i = 0; i < 3; i++) pulse("R3 up from zero", 1'b1, 1'b0);
      step = 1'b0;
      sel_n = 1'b1;
      wait_cyc(SETTLE);
      expect_now("R10 coincident fall and release", 1'b0);
      step = 1'b1;
      wait_cyc(SETTLE);
      warm_reset("R10 nothing stored");

      wait_cyc(3);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule